// File: doc/BRIEF.md
# Edge-selectable external event counter

This block counts transitions on an asynchronous external pulse line. The line is first brought into the system clock domain. An edge detector then picks out either its rising or its falling transitions, as the edge-select register chooses. Each selected transition advances an 8-bit count by one while the count-enable control is high.

The count runs in clear-and-restart mode against a programmable compare register. In the clock cycle in which the count first shows the compare value, a one-cycle interrupt request pulse is raised. The next selected edge returns the count to 00h, and the cycle repeats for as long as counting stays enabled.

Typical use: program the edge and the compare value N, raise count-enable, and take one interrupt for every N+1 selected edges (one for every edge when N is 00h).

Top module: `edge_event_counter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), count reads 00h and irq is 0.
- R2: With edge_sel equal to 01h, each rising transition of evt_in advances count by one, and falling transitions are not counted.
- R3: With edge_sel equal to any value other than 01h (00h included), each falling transition of evt_in advances count by one, and rising transitions are not counted.
- R4: While cnt_en is 0, count is held at 00h from the next clock edge and irq stays 0, whatever evt_in does. After cnt_en returns to 1, counting restarts from 00h.
- R5: With compare value N, count steps 00h, 01h, ... N, and the next selected edge after N loads 00h. Every change of count is either +1 (modulo 256) or a load of 00h.
- R6: irq is high for exactly one clock, in the cycle in which count first shows the compare value that was in force at that edge, and it recurs on every match.
- R7: With a compare value of 00h, every selected edge leaves count at 00h and raises irq.
- R8: A write to cmp_val or edge_sel with no detected edge changes neither count nor irq. A value present at a detected edge applies to that edge, so a compare written in the cycle in which an edge is detected decides the match for that edge.
- R9: evt_in passes through a two-stage synchronizer. A level that changes between clock edges first shows in count after the third following rising clock edge. Each level must be held for at least two clock cycles.
- R10: With a compare value of FFh, count covers the full range 00h to FFh, raises irq at FFh, and then returns to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 1 | Asynchronous external event line |
| cnt_en | input | 1 | Count enable; 0 holds count at 00h |
| edge_sel | input | 8 | Edge select: 01h rising, any other value falling |
| cmp_val | input | 8 | Compare value for clear-and-restart |
| count | output | 8 | Current count value |
| irq | output | 1 | One-cycle interrupt request on compare match |

## Verification
Two functions can fall in the same cycle: the detection of a selected edge and a change to the registers that govern it. This covers a new compare value, a new edge select or a drop of the enable. The bench provokes the first case by writing a new compare value in exactly the cycle in which the synchronized edge is live. It then judges that the match, the interrupt and the clear follow the new value. A behavioural reference model runs on every clock, taking the inputs as they stand at each edge. Its count and interrupt are compared with the outputs in every cycle, so the cases where enable and edge coincide, and the case where compare and edge coincide, are judged wherever they occur.

// File: rtl/evc_pkg.sv
package evc_pkg;
  parameter int unsigned CNT_W = 8;
  parameter int unsigned SEL_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  // Value loaded on a counted edge: wrap to zero after a match, else +1.
  function automatic cnt_t step_count(cnt_t cur, cnt_t lim);
    return (cur == lim) ? '0 : cnt_t'(cur + cnt_t'(1));
  endfunction

  // The interrupt fires when the freshly loaded value equals the compare.
  function automatic logic lands_on(cnt_t nxt, cnt_t lim);
    return nxt == lim;
  endfunction
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evc_edge.sv
module evc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pick_rise,
  output logic hit
);
  logic lvl_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
  assign hit  = pick_rise ? rise : fall;
endmodule

// File: rtl/evc_core.sv
module evc_core
  import evc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  input  cnt_t lim,
  output cnt_t count,
  output logic irq
);
  cnt_t nxt;

  assign nxt = step_count(count, lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      count <= '0;
      irq   <= 1'b0;
    end else if (hit) begin
      count <= nxt;
      irq   <= lands_on(nxt, lim);
    end else begin
      irq   <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import evc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] edge_sel,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [SEL_W-1:0] SEL_RISE = SEL_W'(1);

  logic evt_sync;
  logic pick_rise;
  logic edge_hit;

  assign pick_rise = (edge_sel == SEL_RISE);

  evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (evt_in),
    .q     (evt_sync)
  );

  evc_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (evt_sync),
    .pick_rise (pick_rise),
    .hit       (edge_hit)
  );

  evc_core u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cnt_en),
    .hit   (edge_hit),
    .lim   (cmp_val),
    .count (count),
    .irq   (irq)
  );
endmodule

// File: rtl/evc_chk.sv
module evc_chk
  import evc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cnt_en,
  input cnt_t cmp_val,
  input cnt_t count,
  input logic irq,
  input logic edge_hit
);
  // R4
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (count == '0) && !irq);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == cnt_t'($past(count) + cnt_t'(1))) || (count == '0)));

  // R6
  irq_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == $past(cmp_val)));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !edge_hit) |=> ($stable(count) && !irq));

  // R7
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && edge_hit && (cmp_val == '0)) |=> (irq && (count == '0)));
endmodule

bind edge_event_counter evc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .cmp_val  (cmp_val),
  .count    (count),
  .irq      (irq),
  .edge_hit (edge_hit)
);

// File: tb/test_edge_event_counter.sv
`timescale 1ns/1ps
module test_edge_event_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_in = 1'b0;
  logic       cnt_en = 1'b0;
  logic [7:0] edge_sel = 8'h00;
  logic [7:0] cmp_val = 8'h00;
  logic [7:0] count;
  logic       irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    irq_seen = 0;
  bit    live = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  logic hist[$] = '{1'b0, 1'b0, 1'b0};
  int   m_cnt = 0;
  bit   m_irq = 1'b0;

  always #2.5 clk = ~clk;

  edge_event_counter i_edge_event_counter (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cnt_en(cnt_en),
    .edge_sel(edge_sel), .cmp_val(cmp_val), .count(count), .irq(irq)
  );

  // Behavioural model: the line seen by the edge logic lags evt_in by two
  // clock samples; a selected change between the two oldest samples counts.
  always @(posedge clk) begin
    bit rose, fell, take;
    int nxt;
    if (!rst_n) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_cnt = 0;
      m_irq = 1'b0;
    end else begin
      rose = hist[1] && !hist[0];
      fell = !hist[1] && hist[0];
      take = (edge_sel == 8'h01) ? rose : fell;
      if (!cnt_en) begin
        m_cnt = 0;
        m_irq = 1'b0;
      end else if (take) begin
        nxt = (m_cnt == int'(cmp_val)) ? 0 : (m_cnt + 1) % 256;
        m_irq = (nxt == int'(cmp_val));
        m_cnt = nxt;
      end else begin
        m_irq = 1'b0;
      end
      hist.push_back(evt_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (live) begin
      n_cmp++;
      if (count !== m_cnt[7:0] || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s model: count=%0h irq=%0b expected count=%0h irq=%0b",
                 tag, count, irq, m_cnt[7:0], m_irq);
      end
      if (irq === 1'b1) irq_seen++;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic toggle(input int hold);
    @(negedge clk) evt_in = ~evt_in;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      toggle(hold);
      toggle(hold);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk) cnt_en = 1'b0;
    @(negedge clk) cnt_en = 1'b1;
  endtask

  initial begin
    int base;
    int c0;
    repeat (4) @(negedge clk);
    live = 1'b1;
    tag = "R1";
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 count after release", count, 0);

    // R3: falling edges with 00h and with another non-01h value
    tag = "R3";
    cmp_val = 8'd5; cnt_en = 1'b1;
    pulses(3, 4);
    chk("R3 falling count", count, 3);
    edge_sel = 8'h80;
    base = irq_seen;
    pulses(1, 4);
    chk("R3 sel 80h counts falling", count, 4);

    // R5 / R6: reach compare, then clear
    tag = "R5";
    pulses(1, 4);
    chk("R5 count at compare", count, 5);
    chk("R6 one irq cycle at match", irq_seen - base, 1);
    pulses(1, 4);
    chk("R5 cleared after compare", count, 0);

    // R2: rising edges
    tag = "R2";
    edge_sel = 8'h01; cmp_val = 8'd3;
    pulses(2, 3);
    chk("R2 rising count", count, 2);

    // R8: register writes without an edge
    tag = "R8";
    base = irq_seen;
    @(negedge clk) cmp_val = 8'd2;
    repeat (3) @(negedge clk) edge_sel = 8'h00;
    repeat (3) @(negedge clk) edge_sel = 8'h01;
    repeat (6) @(negedge clk);
    chk("R8 count untouched", count, 2);
    chk("R8 no irq from writes", irq_seen - base, 0);

    // R9: latency through the synchronizer
    tag = "R9";
    cmp_val = 8'd9;
    @(negedge clk) evt_in = 1'b1; c0 = count;
    @(negedge clk);
    @(negedge clk);
    chk("R9 unchanged after two clocks", count, c0);
    @(negedge clk);
    chk("R9 advanced after third clock", count, c0 + 1);
    @(negedge clk) evt_in = 1'b0;
    repeat (4) @(negedge clk);

    // R8: compare written in the cycle the edge is live
    tag = "R8";
    @(negedge clk) evt_in = 1'b1;
    @(negedge clk);
    @(negedge clk) cmp_val = 8'd4;
    @(negedge clk);
    chk("R8 count with same-cycle compare", count, 4);
    chk("R8 irq with same-cycle compare", irq, 1);
    @(negedge clk) evt_in = 1'b0;
    repeat (4) @(negedge clk);

    // R4: enable low holds at zero
    tag = "R4";
    cmp_val = 8'd20;
    pulses(2, 3);
    @(negedge clk) cnt_en = 1'b0;
    @(negedge clk);
    chk("R4 cleared by enable low", count, 0);
    base = irq_seen;
    pulses(3, 3);
    chk("R4 held while disabled", count, 0);
    chk("R4 no irq while disabled", irq_seen - base, 0);
    @(negedge clk) cnt_en = 1'b1;
    pulses(1, 3);
    chk("R4 restart from zero", count, 1);

    // R7: compare zero
    tag = "R7";
    cmp_val = 8'd0;
    restart();
    base = irq_seen;
    pulses(3, 3);
    chk("R7 count stays zero", count, 0);
    chk("R7 irq per edge", irq_seen - base, 3);

    // R10: full range at minimum hold
    tag = "R10";
    cmp_val = 8'hFF;
    restart();
    base = irq_seen;
    pulses(255, 2);
    chk("R10 count at FFh", count, 8'hFF);
    chk("R10 single irq at FFh", irq_seen - base, 1);
    pulses(1, 2);
    chk("R10 wraps to zero", count, 0);

    live = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule